// File: doc/BRIEF.md
# Byte-Shifter Read Controller for a 12-bit Serial Converter

This block is the host side of a read from a 12-bit serial analog-to-digital converter. It gets one result through an 8-bit shifter that takes the first bit it receives as bit 0. A start pulse begins a read. The controller selects the converter and gives two clock edges for the sample window. It then clocks in three bytes and drops the selection.

The converter sends its word MSB first and then sends it again LSB first. The shifter therefore sees the second copy in the correct MSB-first order. The first byte holds the null bit and the upper data bits in reversed order, so it is thrown away. The result is rebuilt from the third byte and the upper half of the second byte.

The result is given left-justified in a 16-bit word, with a one-cycle done strobe. A half-period input sets how many system clocks each level of the serial clock lasts.

Top module: `adcByteReader`

## Requirements
- R1: After reset, `convSelN` is 1, `serClk` is 0, `busy` is 0, `done` is 0 and `result` is 0.
- R2: A `start` seen high at a clock edge while idle drives `convSelN` low from the next cycle. `serClk` stays low for the first half-period.
- R3: During a read, `serClk` alternates low and high, starting low, with each level lasting H system clocks. This gives 26 rising edges, and the clock stays high after each rise until the next fall. While idle, `serClk` is 0.
- R4: The first two rising edges are not captured. `serData` is sampled on each of the next 24 rising edges into an 8-bit shifter, with the first received bit in bit 0. The first completed byte is discarded.
- R5: When a read ends, `result` becomes {byte3[7:0], byte2[7:4], 4'b0000}. With the converter's data this is the 12-bit word in bits 15..4, MSB at bit 15.
- R6: Exactly 52·H cycles after the start is accepted, `convSelN` returns to 1 and `serClk` to 0. `done` is high for exactly that one cycle, and it is the same cycle in which `result` changes.
- R7: `busy` is high for the whole read, which is exactly the cycles in which `convSelN` is 0. A `start` seen while busy has no effect on the read in progress. A `start` still held high after the end begins a new read.
- R8: `result` keeps its value except in the cycle where `done` is high.
- R9: A half-period input of 0 behaves as a half-period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one read |
| halfPeriod | input | DIV_W | System clocks per serial clock level (H) |
| serData | input | 1 | Serial data from the converter |
| convSelN | output | 1 | Active-low converter select |
| serClk | output | 1 | Serial clock to the converter |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle pulse when `result` updates |
| result | output | OUT_W | Left-justified 12-bit result |

## Verification
The assertions assume that `halfPeriod` stays constant from the start of a read until its `done`. They also assume `serData` changes only while `serClk` is low, as a converter does when it shifts data out on falling edges. The bench changes the half-period and the converter word only while `busy` is low. Its converter model updates `serData` on falling `serClk` edges, counted from the falling edge of `convSelN`.

// File: rtl/adcByteReaderPkg.sv
package adcByteReaderPkg;
  // strobes from the sequencer to the capture datapath
  typedef struct packed {
    logic clear;    // new read accepted: reset bit and byte counters
    logic shiftEn;  // rising serial edge that carries a data bit
    logic commit;   // final phase done: load the result word
  } dpStrobe_t;
endpackage

// File: rtl/adcByteReaderCtrl.sv
module adcByteReaderCtrl
  import adcByteReaderPkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int LEAD_EDGES = 2,
  parameter int CAP_EDGES  = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             busy,
  output logic             convSelN,
  output logic             serClk,
  output logic             done,
  output dpStrobe_t        strb
);
  localparam int TOTAL_EDGES     = LEAD_EDGES + CAP_EDGES;
  localparam int LAST_PHASE      = 2 * TOTAL_EDGES - 1;
  localparam int PH_W            = $clog2(LAST_PHASE + 1);
  localparam int FIRST_CAP_PHASE = 2 * LEAD_EDGES + 1;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           state;
  logic [DIV_W-1:0] tick;
  logic [PH_W-1:0]  phase;
  logic [DIV_W-1:0] halfLen;
  logic [PH_W-1:0]  nextPhase;
  logic             phaseEnd;
  logic             lastPhase;

  assign halfLen   = (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
  assign phaseEnd  = (state == ST_RUN) && (tick == halfLen - DIV_W'(1));
  assign nextPhase = phase + PH_W'(1);
  assign lastPhase = (phase == PH_W'(LAST_PHASE));
  assign busy      = (state == ST_RUN);

  always_comb begin
    strb.clear   = (state == ST_IDLE) && start;
    strb.commit  = phaseEnd && lastPhase;
    strb.shiftEn = phaseEnd && !lastPhase && nextPhase[0] &&
                   (nextPhase >= PH_W'(FIRST_CAP_PHASE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tick     <= '0;
      phase    <= '0;
      convSelN <= 1'b1;
      serClk   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            tick     <= '0;
            phase    <= '0;
            convSelN <= 1'b0;
            serClk   <= 1'b0;
          end
        end
        default: begin
          if (phaseEnd) begin
            tick <= '0;
            if (lastPhase) begin
              state    <= ST_IDLE;
              convSelN <= 1'b1;
              serClk   <= 1'b0;
              done     <= 1'b1;
            end else begin
              phase  <= nextPhase;
              serClk <= ~serClk;
            end
          end else begin
            tick <= tick + DIV_W'(1);
          end
        end
      endcase
    end
  end

  // R7
  busy_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy == !convSelN);
  // R3
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serClk);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!serClk && !convSelN));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/adcByteReaderData.sv
module adcByteReaderData
  import adcByteReaderPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int RES_W     = 12,
  parameter int OUT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  dpStrobe_t        strb,
  output logic [OUT_W-1:0] result
);
  localparam int BC_W     = $clog2(BYTE_W);
  localparam int NB_W     = $clog2(NUM_BYTES + 1);
  localparam int LOW_BITS = RES_W - BYTE_W;
  localparam int PAD_BITS = OUT_W - RES_W;

  logic [BYTE_W-1:0]   shReg;
  logic [BYTE_W-1:0]   nextSh;
  logic [BC_W-1:0]     bitCnt;
  logic [NB_W-1:0]     byteIdx;
  logic [BYTE_W-1:0]   hiByte;
  logic [LOW_BITS-1:0] loNib;
  logic                byteDone;

  // first received bit ends up in bit 0 after a full byte
  assign nextSh   = {serData, shReg[BYTE_W-1:1]};
  assign byteDone = strb.shiftEn && (bitCnt == BC_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (strb.clear) begin
      shReg   <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (strb.shiftEn) begin
      shReg <= nextSh;
      if (byteDone) begin
        bitCnt  <= '0;
        byteIdx <= byteIdx + NB_W'(1);
      end else begin
        bitCnt <= bitCnt + BC_W'(1);
      end
    end
  end

  // earlier bytes are dropped; only the last two are kept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiByte <= '0;
      loNib  <= '0;
    end else if (byteDone) begin
      if (byteIdx == NB_W'(NUM_BYTES - 1)) hiByte <= nextSh;
      if (byteIdx == NB_W'(NUM_BYTES - 2)) loNib  <= nextSh[BYTE_W-1 -: LOW_BITS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (strb.commit) result <= {hiByte, loNib, {PAD_BITS{1'b0}}};
  end

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(result));
  // R4
  byte_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (byteIdx == NB_W'(NUM_BYTES) && bitCnt == '0));
endmodule

// File: rtl/adcByteReader.sv
module adcByteReader
  import adcByteReaderPkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int BYTE_W     = 8,
  parameter int NUM_BYTES  = 3,
  parameter int LEAD_EDGES = 2,
  parameter int RES_W      = 12,
  parameter int OUT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic             serData,
  output logic             convSelN,
  output logic             serClk,
  output logic             busy,
  output logic             done,
  output logic [OUT_W-1:0] result
);
  localparam int CAP_EDGES = BYTE_W * NUM_BYTES;

  dpStrobe_t strb;

  adcByteReaderCtrl #(
    .DIV_W(DIV_W), .LEAD_EDGES(LEAD_EDGES), .CAP_EDGES(CAP_EDGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .halfPeriod(halfPeriod),
    .busy(busy), .convSelN(convSelN), .serClk(serClk), .done(done),
    .strb(strb)
  );

  adcByteReaderData #(
    .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .RES_W(RES_W), .OUT_W(OUT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .serData(serData), .strb(strb), .result(result)
  );
endmodule

// File: tb/adcByteReader_bench.sv
`timescale 1ns/1ps
module adcByteReader_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  halfPeriod = 8'd1;
  logic        serData;
  logic        convSelN, serClk, busy, done;
  logic [15:0] result;

  logic [11:0] curWord = 12'h000;
  int nChk = 0, nFail = 0, cycles = 0, fallCnt = 0;
  bit finished = 0;

  // model state
  int mCyc = -1;
  bit mDone = 0;
  logic [15:0] mRes = 16'h0;

  always #4 clk = ~clk;

  adcByteReader u_adcByteReader (
    .clk(clk), .rstN(rstN), .start(start), .halfPeriod(halfPeriod),
    .serData(serData), .convSelN(convSelN), .serClk(serClk), .busy(busy),
    .done(done), .result(result)
  );

  // converter model: data changes on falling serial clock edges
  function automatic logic adcBit(input logic [11:0] w, input int k);
    if (k >= 3 && k <= 14) return w[14-k];
    if (k >= 15 && k <= 25) return w[k-14];
    return 1'b0;
  endfunction

  always @(negedge convSelN) fallCnt = 0;
  always @(negedge serClk) if (!convSelN) fallCnt = fallCnt + 1;
  assign serData = convSelN ? 1'b0 : adcBit(curWord, fallCnt);

  function automatic int effHalf();
    return (halfPeriod == 8'd0) ? 1 : int'(halfPeriod);   // R9
  endfunction

  // cycle reference model
  always @(posedge clk) begin
    mDone = 0;
    if (!rstN) begin
      mCyc = -1;
      mRes = 16'h0;
    end else if (mCyc < 0) begin
      if (start) mCyc = 0;
    end else if (mCyc == 52 * effHalf() - 1) begin
      mCyc  = -1;
      mDone = 1;
      mRes  = {curWord, 4'h0};
    end else begin
      mCyc = mCyc + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit eBusy, eClk;
      eBusy = (mCyc >= 0);
      eClk  = eBusy && (((mCyc / effHalf()) % 2) == 1);
      check(busy === eBusy, "R7 busy", busy, eBusy);
      check(convSelN === !eBusy, "R2 select", convSelN, !eBusy);
      check(serClk === eClk, "R3 serial clock", serClk, eClk);
      check(done === mDone, "R6 done", done, mDone);
      if (mDone) check(result === mRes, "R5 result", result, mRes);
      else       check(result === mRes, "R8 result hold", result, mRes);
    end
  end

  task automatic finishRun();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog R6 actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  task automatic doRead(input logic [11:0] w, input logic [7:0] h);
    @(negedge clk);
    curWord    = w;
    halfPeriod = h;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(convSelN === 1'b1 && serClk === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1 idle outputs", {convSelN, serClk, busy, done}, 4'b1000);
    check(result === 16'h0, "R1 result", result, 16'h0);

    doRead(12'hA5C, 8'd1);   // R4 R5
    doRead(12'h000, 8'd2);
    doRead(12'hFFF, 8'd3);
    doRead(12'h801, 8'd1);
    doRead(12'h3C7, 8'd0);   // R9 zero half-period

    // R7 start during a read is ignored
    @(negedge clk);
    curWord = 12'h5A3; halfPeriod = 8'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone();
    check(result === 16'h5A30, "R5 after ignored start", result, 16'h5A30);

    // R7 start held across the end starts the next read at once
    repeat (2) @(negedge clk);
    curWord = 12'h1E6; start = 1'b1;
    waitDone();
    @(negedge clk);
    check(busy === 1'b1, "R7 back-to-back restart", busy, 1'b1);
    start = 1'b0;
    waitDone();
    check(result === 16'h1E60, "R5 back-to-back result", result, 16'h1E60);
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule